// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block turns an asynchronous serial line carrying 8-bit characters (no parity, one stop bit) into bytes held in a small queue. The line is examined on a sample tick that runs at four times the bit rate. The tick comes from a 16-bit divisor that is built from two byte-wide inputs. The tick fires once every divisor+1 system clocks, so software sets the divisor to clock/(baud*4) - 1.

The incoming line is first passed through a two-flop synchronizer. A falling edge starts a frame. The line is checked again two ticks later, near the middle of the start bit, and if it has gone high again the edge is treated as noise. After a confirmed start, each data bit is sampled four ticks after the previous sample, least significant bit first, and then the stop bit is sampled the same way.

Finished bytes enter a four-entry first-in first-out queue. The consumer sees the oldest byte and removes it with a one-cycle read strobe. Several bytes can wait in the queue, so the consumer keeps reading until the empty flag returns. Frame and overrun errors are sticky and are cleared by a separate pulse.

Top module: `serial_rx_os4`

## Requirements
- R1: After reset, q_empty is 1, q_full and q_one_left are 0, and frame_err and overrun_err are 0.
- R2: The sample tick fires every {div_hi,div_lo}+1 clocks, and one bit period is four ticks. A byte sent at a bit period of 4*(divisor+1) clocks is received correctly. When the divisor changes, the tick counter restarts, so the new rate takes effect at once.
- R3: A frame is one low start bit, then 8 data bits sent LSB first, then one high stop bit. The byte received equals the data bits.
- R4: If the line has returned high when it is checked two ticks after a falling edge, the edge is discarded and nothing is stored.
- R5: The queue returns bytes in arrival order. rd_data shows the oldest byte. A one-cycle rd_pop removes that byte.
- R6: q_one_left is 1 exactly when 3 of the 4 entries are in use. q_full is 1 exactly when all 4 are in use. q_empty is 1 exactly when none is in use.
- R7: A byte that completes while the queue is full is dropped, sets overrun_err, and leaves the stored bytes unchanged.
- R8: A stop bit sampled low sets frame_err. The byte is still stored. frame_err and overrun_err stay set until an err_clr pulse clears them.
- R9: rd_pop while the queue is empty has no effect. The flags stay as they are, and the next byte is received and read normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo | input | 8 | Low byte of the tick divisor |
| div_hi | input | 8 | High byte of the tick divisor |
| rx_line | input | 1 | Asynchronous serial input; idles high |
| rd_pop | input | 1 | One-cycle strobe that removes the oldest byte |
| err_clr | input | 1 | Pulse that clears both error flags |
| rd_data | output | 8 | Oldest byte in the queue |
| q_empty | output | 1 | Queue holds no byte |
| q_full | output | 1 | All four queue entries are in use |
| q_one_left | output | 1 | Exactly one queue entry is free |
| frame_err | output | 1 | Sticky: a stop bit was sampled low |
| overrun_err | output | 1 | Sticky: a byte was dropped because the queue was full |

## Verification
The bench builds the block with its default parameters: 8 data bits, a 16-bit divisor, four samples per bit and a four-entry queue. With a four-deep queue, the one-space-left, full and overrun cases are reached after only five frames. The divisor is run at 3 and at 9, which gives bit periods of 16 and 40 clocks. These two rates exercise a rate change and leave enough room to send a noise pulse shorter than the mid-start check.

// File: rtl/serial_rx_os4_pkg.sv
package serial_rx_os4_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } frame_st_e;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q;
  logic             restart;
  logic             at_end;

  // A changed divisor clears the count so the new rate starts cleanly
  assign restart = (div_i != div_q);
  assign at_end  = (cnt_q == div_q);
  assign tick_o  = at_end && !restart;

  always_comb begin
    if (restart || at_end) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_i;
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_os4_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 line_i,
  input  logic                 fall_i,
  output logic                 done_o,
  output logic                 stop_bad_o,
  output logic [DATA_BITS-1:0] byte_o
);
  localparam int PH_W  = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [PH_W-1:0]  PH_MID  = PH_W'(OSR/2 - 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OSR - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  frame_st_e            st_q, st_d;
  logic [PH_W-1:0]      ph_q, ph_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [DATA_BITS-1:0] shf_q, shf_d;
  logic                 done_d, bad_d;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    shf_d  = shf_q;
    done_d = 1'b0;
    bad_d  = 1'b0;
    unique case (st_q)
      FR_IDLE: begin
        if (fall_i) begin
          st_d = FR_START;
          ph_d = '0;
        end
      end
      FR_START: begin
        if (tick_i) begin
          if (ph_q == PH_MID) begin
            ph_d  = '0;
            bit_d = '0;
            st_d  = line_i ? FR_IDLE : FR_DATA;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      FR_DATA: begin
        if (tick_i) begin
          if (ph_q == PH_LAST) begin
            ph_d  = '0;
            shf_d = {line_i, shf_q[DATA_BITS-1:1]};
            if (bit_q == BIT_LAST) st_d = FR_STOP;
            else                   bit_d = bit_q + 1'b1;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      FR_STOP: begin
        if (tick_i) begin
          if (ph_q == PH_LAST) begin
            ph_d   = '0;
            done_d = 1'b1;
            bad_d  = !line_i;
            st_d   = FR_IDLE;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FR_IDLE;
      ph_q       <= '0;
      bit_q      <= '0;
      shf_q      <= '0;
      done_o     <= 1'b0;
      stop_bad_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      ph_q       <= ph_d;
      bit_q      <= bit_d;
      shf_q      <= shf_d;
      done_o     <= done_d;
      stop_bad_o <= bad_d;
    end
  end

  assign byte_o = shf_q;
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         one_left_o,
  output logic         drop_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_ONE  = CW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CNT_FULL);
  assign one_left_o = (cnt_q == CNT_ONE);
  // Fullness is judged before any pop in the same cycle
  assign do_push    = push_i && !full_o;
  assign do_pop     = pop_i && !empty_o;
  assign drop_o     = push_i && full_o;
  assign head_o     = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && (wp_q == PW'(gi))) mem[gi] <= data_i;
      end
    end
  endgenerate
endmodule

// File: rtl/serial_rx_os4.sv
module serial_rx_os4 #(
  parameter int DATA_BITS = 8,
  parameter int DIV_W     = 16,
  parameter int OSR       = 4,
  parameter int Q_DEPTH   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W/2-1:0]   div_lo,
  input  logic [DIV_W/2-1:0]   div_hi,
  input  logic                 rx_line,
  input  logic                 rd_pop,
  input  logic                 err_clr,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 q_empty,
  output logic                 q_full,
  output logic                 q_one_left,
  output logic                 frame_err,
  output logic                 overrun_err
);
  logic [DIV_W-1:0]     div_w;
  logic                 tick;
  logic                 sync1_q, sync2_q, prev_q;
  logic                 line_fall;
  logic                 push_ev;
  logic                 stop_bad;
  logic [DATA_BITS-1:0] rx_byte;
  logic                 drop_ev;
  logic                 ferr_d, oerr_d;

  assign div_w = {div_hi, div_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= rx_line;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign line_fall = prev_q && !sync2_q;

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .div_i (div_w),
    .tick_o(tick)
  );

  rx_frame_fsm #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .line_i    (sync2_q),
    .fall_i    (line_fall),
    .done_o    (push_ev),
    .stop_bad_o(stop_bad),
    .byte_o    (rx_byte)
  );

  rx_byte_queue #(.W(DATA_BITS), .DEPTH(Q_DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_ev),
    .data_i    (rx_byte),
    .pop_i     (rd_pop),
    .head_o    (rd_data),
    .empty_o   (q_empty),
    .full_o    (q_full),
    .one_left_o(q_one_left),
    .drop_o    (drop_ev)
  );

  // Sticky error flags; a new event wins over a clear in the same cycle
  always_comb begin
    ferr_d = err_clr ? 1'b0 : frame_err;
    oerr_d = err_clr ? 1'b0 : overrun_err;
    if (push_ev && stop_bad) ferr_d = 1'b1;
    if (drop_ev)             oerr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_err   <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      frame_err   <= ferr_d;
      overrun_err <= oerr_d;
    end
  end
endmodule

// File: rtl/serial_rx_os4_chk.sv
module serial_rx_os4_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_pop,
  input logic                 err_clr,
  input logic                 push_ev,
  input logic [DATA_BITS-1:0] rd_data,
  input logic                 q_empty,
  input logic                 q_full,
  input logic                 q_one_left,
  input logic                 frame_err,
  input logic                 overrun_err
);
  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full)); // R6
  AST_ONE_LEFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    q_one_left |-> (!q_full && !q_empty)); // R6
  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty && !rd_pop) |=> $stable(rd_data)); // R5
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !rd_pop) |=> q_full); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_err && !err_clr) |=> overrun_err); // R8
  AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clr) |=> frame_err); // R8
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !push_ev) |=> q_empty); // R9
endmodule

bind serial_rx_os4 serial_rx_os4_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_pop     (rd_pop),
  .err_clr    (err_clr),
  .push_ev    (push_ev),
  .rd_data    (rd_data),
  .q_empty    (q_empty),
  .q_full     (q_full),
  .q_one_left (q_one_left),
  .frame_err  (frame_err),
  .overrun_err(overrun_err)
);

// File: tb/serial_rx_os4_tb.sv
module serial_rx_os4_tb;
  logic       clk;
  logic       rst_n;
  logic [7:0] div_lo, div_hi;
  logic       rx_line, rd_pop, err_clr;
  logic [7:0] rd_data;
  logic       q_empty, q_full, q_one_left, frame_err, overrun_err;

  int n_chk  = 0;
  int n_fail = 0;
  int div_v  = 3;

  serial_rx_os4 u_dut (
    .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
    .rx_line(rx_line), .rd_pop(rd_pop), .err_clr(err_clr),
    .rd_data(rd_data), .q_empty(q_empty), .q_full(q_full),
    .q_one_left(q_one_left), .frame_err(frame_err), .overrun_err(overrun_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_div(input int d);
    @(negedge clk);
    div_v  = d;
    div_lo = d[7:0];
    div_hi = d[15:8];
    repeat (8) @(negedge clk);
  endtask

  // One frame; bit period is 4*(div+1) clocks
  task automatic send(input logic [7:0] b, input logic stop_v);
    int p;
    p = 4 * (div_v + 1);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (p) @(negedge clk);
    end
    rx_line = stop_v;
    repeat (p) @(negedge clk);
    rx_line = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  task automatic pop_expect(input string tag, input logic [7:0] exp);
    @(negedge clk);
    check({tag, " not empty"}, q_empty, 0);
    check({tag, " data"}, rd_data, exp);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 empty", q_empty, 1);
    check("R1 full", q_full, 0);
    check("R1 one_left", q_one_left, 0);
    check("R1 frame_err", frame_err, 0);
    check("R1 overrun_err", overrun_err, 0);
  endtask

  task automatic t_basic();
    set_div(3);
    send(8'hA5, 1'b1);
    send(8'h3C, 1'b1);
    pop_expect("R3 first", 8'hA5);
    pop_expect("R3 second", 8'h3C);
    check("R3 empty after", q_empty, 1);
  endtask

  task automatic t_rate();
    set_div(9);
    send(8'h81, 1'b1);
    pop_expect("R2 div9", 8'h81);
    set_div(3);
    send(8'h7E, 1'b1);
    pop_expect("R2 back to div3", 8'h7E);
  endtask

  task automatic t_glitch();
    set_div(9);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (5) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    check("R4 glitch ignored", q_empty, 1);
    send(8'h5A, 1'b1);
    pop_expect("R4 after glitch", 8'h5A);
    set_div(3);
  endtask

  task automatic t_fill();
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    send(8'h33, 1'b1);
    check("R6 one_left at 3", q_one_left, 1);
    check("R6 not full at 3", q_full, 0);
    send(8'h44, 1'b1);
    check("R6 full at 4", q_full, 1);
    check("R6 one_left clear at 4", q_one_left, 0);
    check("R7 no overrun yet", overrun_err, 0);
    send(8'h99, 1'b1);
    check("R7 overrun set", overrun_err, 1);
    pop_expect("R7 keep 1", 8'h11);
    pop_expect("R5 order 2", 8'h22);
    pop_expect("R5 order 3", 8'h33);
    pop_expect("R7 keep 4", 8'h44);
    check("R7 dropped byte absent", q_empty, 1);
    check("R8 overrun still set", overrun_err, 1);
    clear_err();
    check("R8 overrun cleared", overrun_err, 0);
  endtask

  task automatic t_frame();
    send(8'h55, 1'b0);
    check("R8 frame_err set", frame_err, 1);
    send(8'hC3, 1'b1);
    check("R8 frame_err sticky", frame_err, 1);
    pop_expect("R8 bad-stop byte kept", 8'h55);
    pop_expect("R8 next byte", 8'hC3);
    clear_err();
    check("R8 frame_err cleared", frame_err, 0);
  endtask

  task automatic t_pop_empty();
    @(negedge clk);
    rd_pop = 1'b1;
    repeat (3) @(negedge clk);
    rd_pop = 1'b0;
    check("R9 still empty", q_empty, 1);
    check("R9 one_left clear", q_one_left, 0);
    send(8'hE7, 1'b1);
    pop_expect("R9 after empty pop", 8'hE7);
    check("R9 empty again", q_empty, 1);
  endtask

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; rd_pop = 1'b0; err_clr = 1'b0;
    div_lo = 8'd3; div_hi = 8'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rate();
    t_glitch();
    t_fill();
    t_frame();
    t_pop_empty();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule